// File: doc/BRIEF.md
# Predicated element-step skip unit

This unit sits beside the issue sequencer of a vector-capable core. A vectorised instruction walks its elements with two counters, one for source elements and one for destination elements. Each counter has its own predicate mask. Before an element is issued, the sequencer strobes this unit with the current counters, both masks, the vector length and a zeroing flag for each side. One cycle later the unit returns counters that have been moved forward past every element whose mask bit is clear.

A counter never moves past the vector length. When a side requests zeroing, that side's counter is left where it is, because masked-out elements must still be visited so that zeros can be written. When either counter moves, the unit raises an update flag. The sequencer then decodes the instruction again against the new step state.

Each side builds a candidate vector. It holds the mask bits at or above the current step and below VL, plus one bit at position VL. A lowest-index priority encoder over this vector gives the new step directly. The bit at VL marks where the walk ends.

Top module: `pred_step_skip`

## Requirements
- R1: `valid_o` is high in the cycle after each cycle in which `req_i` is high, and is low in every other cycle.
- R2: With zeroing off, a step whose mask bit at the current step index is 1, and which is below VL, is returned unchanged.
- R3: With zeroing off, a step below VL is returned as the lowest index that is at or above the step, below VL, and has its mask bit (bit n of the 64-bit mask is element n) set to 1.
- R4: With zeroing off, if no mask bit is set from the step up to VL−1, the step is returned as VL.
- R5: A step already at or above VL is returned unchanged. No returned step exceeds VL. A VL above 64 is treated as 64, and mask bits at or above VL are ignored.
- R6: When a side's zeroing flag is 1, that side's step is returned unchanged whatever its mask holds.
- R7: The source result depends only on the source mask, source step, source zeroing flag and VL. The destination result likewise depends only on its own inputs and VL.
- R8: `update_o` is 1 together with `valid_o` exactly when at least one returned step differs from its input step. It is 0 whenever `valid_o` is 0.
- R9: After reset both step outputs are 0 and `valid_o` and `update_o` are 0. Step outputs hold their last values between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; inputs are sampled on this cycle |
| src_mask_i | input | 64 | Source predicate mask, bit n for element n |
| dst_mask_i | input | 64 | Destination predicate mask, bit n for element n |
| src_step_i | input | 7 | Current source step |
| dst_step_i | input | 7 | Current destination step |
| vl_i | input | 7 | Vector length (values above 64 treated as 64) |
| src_zero_i | input | 1 | Source zeroing requested; disables source skip |
| dst_zero_i | input | 1 | Destination zeroing requested; disables destination skip |
| src_step_o | output | 7 | New source step |
| dst_step_o | output | 7 | New destination step |
| update_o | output | 1 | A step changed; the instruction must be decoded again |
| valid_o | output | 1 | Results valid (one cycle after `req_i`) |

## Verification
Every result passes through a single register stage. The new steps, `update_o` and `valid_o` are therefore all due at the clock edge after the one that samples `req_i`. The bench drives a request on a falling edge and drops `req_i` on the next falling edge. It then reads all outputs at that point, half a cycle after the edge that loaded them. One more falling edge later it checks that `valid_o` and `update_o` have dropped and that the steps are still held.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_SRC  = 0;
  localparam int unsigned SIDE_DST  = 1;
endpackage

// File: rtl/pss_find_first.sv
module pss_find_first #(
  parameter int unsigned W  = 65,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // lowest set index wins; scan downward so the last hit is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pss_lane.sv
module pss_lane #(
  parameter int unsigned MASK_W = 64,
  localparam int unsigned STEP_W = $clog2(MASK_W + 1)
) (
  input  logic [MASK_W-1:0] mask_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic              zero_i,
  output logic [STEP_W-1:0] step_o
);
  logic [MASK_W:0]   cand;
  logic [STEP_W-1:0] first;
  logic              hold;

  // window [step, vl) of mask, plus terminator bit at vl
  always_comb begin
    for (int i = 0; i < MASK_W; i++) begin
      cand[i] = (mask_i[i] && (STEP_W'(i) >= step_i) && (STEP_W'(i) < vl_i))
                || (STEP_W'(i) == vl_i);
    end
    cand[MASK_W] = 1'b1;
  end

  pss_find_first #(.W(MASK_W + 1)) u_ff (
    .vec_i (cand),
    .idx_o (first)
  );

  assign hold   = zero_i || (step_i >= vl_i);
  assign step_o = hold ? step_i : first;
endmodule

// File: rtl/pred_step_skip.sv
module pred_step_skip #(
  parameter int unsigned MASK_W = 64,
  localparam int unsigned STEP_W = $clog2(MASK_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MASK_W-1:0] src_mask_i,
  input  logic [MASK_W-1:0] dst_mask_i,
  input  logic [STEP_W-1:0] src_step_i,
  input  logic [STEP_W-1:0] dst_step_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic              src_zero_i,
  input  logic              dst_zero_i,
  output logic [STEP_W-1:0] src_step_o,
  output logic [STEP_W-1:0] dst_step_o,
  output logic              update_o,
  output logic              valid_o
);
  import pss_pkg::*;

  logic [STEP_W-1:0] vl_c;
  logic [MASK_W-1:0] mask_a [NUM_SIDES];
  logic [STEP_W-1:0] step_a [NUM_SIDES];
  logic              zero_a [NUM_SIDES];
  logic [STEP_W-1:0] nxt_a  [NUM_SIDES];
  logic [NUM_SIDES-1:0] moved;

  assign vl_c = (vl_i > STEP_W'(MASK_W)) ? STEP_W'(MASK_W) : vl_i;

  assign mask_a[SIDE_SRC] = src_mask_i;
  assign mask_a[SIDE_DST] = dst_mask_i;
  assign step_a[SIDE_SRC] = src_step_i;
  assign step_a[SIDE_DST] = dst_step_i;
  assign zero_a[SIDE_SRC] = src_zero_i;
  assign zero_a[SIDE_DST] = dst_zero_i;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    pss_lane #(.MASK_W(MASK_W)) u_lane (
      .mask_i (mask_a[s]),
      .step_i (step_a[s]),
      .vl_i   (vl_c),
      .zero_i (zero_a[s]),
      .step_o (nxt_a[s])
    );
    assign moved[s] = nxt_a[s] != step_a[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_step_o <= '0;
      dst_step_o <= '0;
      update_o   <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o  <= req_i;
      update_o <= req_i && (|moved);
      if (req_i) begin
        src_step_o <= nxt_a[SIDE_SRC];
        dst_step_o <= nxt_a[SIDE_DST];
      end
    end
  end
endmodule

// File: rtl/pred_step_skip_chk.sv
module pred_step_skip_chk #(
  parameter int unsigned MASK_W = 64,
  localparam int unsigned STEP_W = $clog2(MASK_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [MASK_W-1:0] src_mask_i,
  input logic [MASK_W-1:0] dst_mask_i,
  input logic [STEP_W-1:0] src_step_i,
  input logic [STEP_W-1:0] dst_step_i,
  input logic [STEP_W-1:0] vl_i,
  input logic              src_zero_i,
  input logic              dst_zero_i,
  input logic [STEP_W-1:0] src_step_o,
  input logic [STEP_W-1:0] dst_step_o,
  input logic              update_o,
  input logic              valid_o
);
  logic [STEP_W-1:0] vl_lim;
  assign vl_lim = (vl_i > STEP_W'(MASK_W)) ? STEP_W'(MASK_W) : vl_i;

  a_r1_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  a_r1_valid_only_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  a_r5_src_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (src_step_o <= $past(vl_lim)) || (src_step_o == $past(src_step_i)));
  a_r5_dst_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dst_step_o <= $past(vl_lim)) || (dst_step_o == $past(dst_step_i)));
  a_r3_src_no_backstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> src_step_o >= $past(src_step_i));
  a_r3_src_lands_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(src_zero_i) && (src_step_o < $past(vl_lim)))
      |-> (($past(src_mask_i) >> src_step_o) & MASK_W'(1)) != '0);
  a_r6_src_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(src_zero_i)) |-> src_step_o == $past(src_step_i));
  a_r6_dst_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dst_zero_i)) |-> dst_step_o == $past(dst_step_i));
  a_r8_update_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> update_o == ((src_step_o != $past(src_step_i)) ||
                             (dst_step_o != $past(dst_step_i))));
  a_r8_update_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !update_o);
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(src_step_o) && $stable(dst_step_o)));
endmodule

bind pred_step_skip pred_step_skip_chk #(.MASK_W(MASK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .src_mask_i (src_mask_i),
  .dst_mask_i (dst_mask_i),
  .src_step_i (src_step_i),
  .dst_step_i (dst_step_i),
  .vl_i       (vl_i),
  .src_zero_i (src_zero_i),
  .dst_zero_i (dst_zero_i),
  .src_step_o (src_step_o),
  .dst_step_o (dst_step_o),
  .update_o   (update_o),
  .valid_o    (valid_o)
);

// File: tb/pred_step_skip_bench.sv
`timescale 1ns/1ps
module pred_step_skip_bench;
  localparam int unsigned MW = 64;
  localparam int unsigned SW = 7;
  localparam int NV = 10;

  typedef struct packed {
    logic [MW-1:0] sm;
    logic [MW-1:0] dm;
    logic [SW-1:0] ss;
    logic [SW-1:0] ds;
    logic [SW-1:0] vl;
    logic          sz;
    logic          dz;
    logic [SW-1:0] es;
    logic [SW-1:0] ed;
    logic          eu;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{64'h1, 64'h1, 7'd0, 7'd0, 7'd8, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0},
    '{64'h20, 64'h8, 7'd1, 7'd0, 7'd8, 1'b0, 1'b0, 7'd5, 7'd3, 1'b1},
    '{64'h20, 64'h0, 7'd6, 7'd2, 7'd8, 1'b0, 1'b0, 7'd8, 7'd8, 1'b1},
    '{64'h0, 64'h0, 7'd3, 7'd5, 7'd8, 1'b1, 1'b1, 7'd3, 7'd5, 1'b0},
    '{64'h0, 64'h4, 7'd8, 7'd2, 7'd8, 1'b0, 1'b0, 7'd8, 7'd2, 1'b0},
    '{64'h8000_0000_0000_0000, 64'h100_0000_0000, 7'd10, 7'd40, 7'd64, 1'b0, 1'b0, 7'd63, 7'd40, 1'b1},
    '{64'hF0, 64'h0, 7'd0, 7'd0, 7'd4, 1'b0, 1'b0, 7'd4, 7'd4, 1'b1},
    '{64'h2, 64'h2, 7'd0, 7'd0, 7'd100, 1'b0, 1'b0, 7'd1, 7'd1, 1'b1},
    '{64'h0, 64'h10, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0},
    '{64'h0, 64'h0, 7'd2, 7'd2, 7'd6, 1'b1, 1'b0, 7'd2, 7'd6, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [MW-1:0] sm = '0, dm = '0;
  logic [SW-1:0] ss = '0, ds = '0, vl = '0;
  logic          sz = 1'b0, dz = 1'b0;
  logic [SW-1:0] so, dso;
  logic          upd, vld;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pred_step_skip u_pred_step_skip (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .src_mask_i(sm), .dst_mask_i(dm), .src_step_i(ss), .dst_step_i(ds),
    .vl_i(vl), .src_zero_i(sz), .dst_zero_i(dz),
    .src_step_o(so), .dst_step_o(dso), .update_o(upd), .valid_o(vld)
  );

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R5";
      5: return "R3";
      6: return "R5";
      7: return "R5";
      8: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    @(negedge clk);
    sm = v.sm; dm = v.dm; ss = v.ss; ds = v.ds; vl = v.vl; sz = v.sz; dz = v.dz;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9", "src_step after reset", 64'(so), 0);
    chk("R9", "dst_step after reset", 64'(dso), 0);
    chk("R9", "valid after reset", 64'(vld), 0);
    chk("R9", "update after reset", 64'(upd), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      chk(vec_tag(i), "src_step", 64'(so), 64'(VECS[i].es));
      chk(vec_tag(i), "dst_step", 64'(dso), 64'(VECS[i].ed));
      chk("R8", "update", 64'(upd), 64'(VECS[i].eu));
      chk("R1", "valid", 64'(vld), 1);
    end

    // R1/R8/R9: pulse ends, outputs held while idle and inputs change
    drive(VECS[1]);
    sm = '0; dm = '0; ss = 7'd0; ds = 7'd0; vl = 7'd8;
    @(negedge clk);
    chk("R1", "valid drops", 64'(vld), 0);
    chk("R8", "update drops with valid", 64'(upd), 0);
    repeat (3) @(negedge clk);
    chk("R9", "src held", 64'(so), 5);
    chk("R9", "dst held", 64'(dso), 3);

    // R7: changing only dst inputs leaves src result alone
    drive('{64'h20, 64'h8000, 7'd1, 7'd0, 7'd20, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0});
    chk("R7", "src unaffected by dst side", 64'(so), 5);
    chk("R7", "dst follows own mask", 64'(dso), 15);

    // R1: back-to-back requests give back-to-back valid
    @(negedge clk);
    sm = 64'h1; dm = 64'h1; ss = 0; ds = 0; vl = 7'd4; req = 1'b1;
    @(negedge clk);
    sm = 64'h0; dm = 64'h0; ss = 7'd1; ds = 7'd1;
    chk("R1", "first of pair valid", 64'(vld), 1);
    chk("R2", "first of pair src", 64'(so), 0);
    @(negedge clk);
    req = 1'b0;
    chk("R1", "second of pair valid", 64'(vld), 1);
    chk("R4", "second of pair src", 64'(so), 4);
    chk("R8", "second of pair update", 64'(upd), 1);

    // R9: async reset clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "src cleared by reset", 64'(so), 0);
    chk("R9", "valid cleared by reset", 64'(vld), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule